// File: doc/BRIEF.md
# Interrupt-File Indirect Register Router

This block sits between a core's indirect register port and the per-hart interrupt-file state. The core issues one read-modify-write request at a time. Each request carries a privilege level, a virtualization flag, a guest page selector, an 8-bit register select code, a width flag (32 or 64 bits), write data and a write mask. The router first checks whether the privilege and virtualization combination may reach the file, and picks the page it addresses. It then decodes the select code into one of five operations: the delivery enable bit, the threshold, the top-interrupt register, or one word of pending bits or enable bits.

For each accepted request the old value is returned and the masked update is applied. Pending and enable bits live in a bit-array store inside the block and are presented flat on output ports. Delivery and threshold values per page are presented the same way, so that an external priority search can use them. That search drives back the highest pending identity of each page. The router uses it to answer top-interrupt reads and to clear that identity's pending bit on a top-interrupt write.

A small two-state controller (ST_IDLE, ST_RESP) times the response. From either state an incoming request moves it to ST_RESP, and the lack of one moves it to ST_IDLE. ST_RESP is the cycle in which the response is presented.

Top module: `irr_router`

## Requirements
- R1: With MMODE=1, a request is accepted only with privilege 2'b11 (machine) and virtualization 0, and it maps to page 0. Every other privilege or virtualization combination returns an error.
- R2: With MMODE=0, privilege 2'b01 (supervisor) with virtualization 0 maps to page 0. With virtualization 1, the guest selector must be nonzero and below NPAGES, and it becomes the page. All other combinations are errors.
- R3: Select codes are 8'h70 delivery, 8'h72 threshold, 8'h74 top-interrupt, 8'h80–8'hBF pending words and 8'hC0–8'hFF enable words. The word number is sel[5:0]. Any other code is an error.
- R4: When req_wide=1, an odd word number is an error and an even one is halved. The resulting index must be below NIDS/64 when wide and below NIDS/32 when narrow, or the request is an error.
- R5: A word read returns the old pending or enable bits, with bit i holding identity base+i of the page. Base is index×64 when wide and index×32 when narrow. In narrow mode bits 63:32 read 0.
- R6: A word write changes only the bits whose mask bit is set: a data 1 sets the state bit and a data 0 clears it. In narrow mode mask bits 63:32 have no effect. No other page or word changes.
- R7: Identity 0 of every page has its pending and enable bits always 0, and writes to them are ignored.
- R8: Delivery (bit 0) and threshold (bits IDW-1:0) are updated as old with the masked bits replaced by data, and the read returns the old value zero-extended.
- R9: A top-interrupt read returns the page's top identity in bits 16+IDW-1:16 and in bits IDW-1:0. A top-interrupt write with a nonzero effective mask clears that identity's pending bit when the identity is nonzero. The write data is ignored.
- R10: rsp_valid is high exactly in the cycle after each req_valid cycle. On an error, rsp_err is 1, rsp_rdata is 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_priv | input | 2 | Privilege level of the access |
| req_virt | input | 1 | Virtualization flag |
| req_gsel | input | GSEL_W | Guest page selector |
| req_sel | input | 8 | Register select code |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_wdata | input | 64 | Write data |
| req_wmask | input | 64 | Write mask |
| top_id_i | input | NPAGES*IDW | Top pending identity of each page from the external search |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 64 | Old register value, zero on error |
| deliv_o | output | NPAGES | Delivery enable per page |
| thresh_o | output | NPAGES*IDW | Threshold per page |
| pend_o | output | NPAGES*NIDS | Pending bits, page-major |
| en_o | output | NPAGES*NIDS | Enable bits, page-major |

## Verification
A wrong page choice or a wrong word base makes the state ports change in an unexpected page or bit range on the edge that closes the request. A later read through the router then returns the misplaced bits in the very next response. A decode fault that accepts a bad code, or rejects a good one, shows on rsp_err one cycle after the request. A missed clear after a top-interrupt write stays visible on pend_o until the bit is written again, so a state comparison after each group of requests exposes it.

// File: rtl/irr_pkg.sv
package irr_pkg;
    typedef enum logic [2:0] {
        OP_DELIV,
        OP_THRESH,
        OP_TOP,
        OP_PEND,
        OP_ENAB,
        OP_BAD
    } irr_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } irr_state_e;

    localparam logic [7:0] SEL_DELIV  = 8'h70;
    localparam logic [7:0] SEL_THRESH = 8'h72;
    localparam logic [7:0] SEL_TOP    = 8'h74;
    localparam logic [1:0] PRIV_S     = 2'b01;
    localparam logic [1:0] PRIV_M     = 2'b11;
endpackage

// File: rtl/irr_page_map.sv
module irr_page_map #(
    parameter bit MMODE  = 1'b0,
    parameter int NPAGES = 4,
    parameter int GSEL_W = 6,
    parameter int PGW    = 2
) (
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic [GSEL_W-1:0] gsel,
    output logic              ok,
    output logic [PGW-1:0]    page
);
    import irr_pkg::*;

    generate
        if (MMODE) begin : g_mach
            always_comb begin
                ok   = (priv == PRIV_M) && !virt;
                page = '0;
            end
        end else begin : g_sup
            always_comb begin
                ok   = 1'b0;
                page = '0;
                if (priv == PRIV_S) begin
                    if (!virt) begin
                        ok = 1'b1;
                    end else if ((gsel != '0) && (int'(gsel) < NPAGES)) begin
                        ok   = 1'b1;
                        page = gsel[PGW-1:0];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irr_sel_decode.sv
module irr_sel_decode #(
    parameter int NIDS = 64,
    parameter int IDW  = 6
) (
    input  logic [7:0]     sel,
    input  logic           wide,
    output irr_pkg::irr_op_e op,
    output logic [IDW-1:0] base
);
    import irr_pkg::*;

    localparam int NW32 = NIDS / 32;
    localparam int NW64 = NIDS / 64;

    logic [5:0] wnum;
    logic       word_ok;
    int         widx;

    always_comb begin
        wnum    = sel[5:0];
        word_ok = 1'b0;
        widx    = 0;
        if (wide) begin
            widx    = int'(wnum >> 1);
            word_ok = !wnum[0] && (widx < NW64);
        end else begin
            widx    = int'(wnum);
            word_ok = widx < NW32;
        end
    end

    always_comb begin
        op   = OP_BAD;
        base = '0;
        if (sel == SEL_DELIV) begin
            op = OP_DELIV;
        end else if (sel == SEL_THRESH) begin
            op = OP_THRESH;
        end else if (sel == SEL_TOP) begin
            op = OP_TOP;
        end else if (sel[7] && word_ok) begin
            op   = sel[6] ? OP_ENAB : OP_PEND;
            base = IDW'(widx * (wide ? 64 : 32));
        end
    end
endmodule

// File: rtl/irr_bit_store.sv
module irr_bit_store #(
    parameter int NPAGES = 4,
    parameter int NIDS   = 64,
    parameter int PGW    = 2,
    parameter int IDW    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PGW-1:0]         page,
    input  logic [IDW-1:0]         base,
    input  logic                   wide,
    input  logic                   use_en,
    input  logic                   wr_en,
    input  logic [63:0]            wdata,
    input  logic [63:0]            wmask,
    input  logic                   clr_en,
    input  logic [IDW-1:0]         clr_id,
    output logic [63:0]            rdata,
    output logic [NPAGES*NIDS-1:0] pend_q,
    output logic [NPAGES*NIDS-1:0] en_q
);
    localparam int TOT = NPAGES * NIDS;

    logic [TOT-1:0] pend_d;
    logic [TOT-1:0] en_d;
    int             width;
    int             origin;

    always_comb begin
        width  = wide ? 64 : 32;
        origin = int'(page) * NIDS + int'(base);
        rdata  = '0;
        for (int i = 0; i < 64; i++) begin
            if ((i < width) && (origin + i < TOT)) begin
                rdata[i] = use_en ? en_q[origin + i] : pend_q[origin + i];
            end
        end
    end

    always_comb begin
        pend_d = pend_q;
        en_d   = en_q;
        if (wr_en) begin
            for (int i = 0; i < 64; i++) begin
                if ((i < width) && wmask[i] && (origin + i < TOT)) begin
                    if (use_en) en_d[origin + i] = wdata[i];
                    else        pend_d[origin + i] = wdata[i];
                end
            end
        end
        if (clr_en && (int'(page) * NIDS + int'(clr_id) < TOT)) begin
            pend_d[int'(page) * NIDS + int'(clr_id)] = 1'b0;
        end
        for (int p = 0; p < NPAGES; p++) begin
            pend_d[p * NIDS] = 1'b0;
            en_d[p * NIDS]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
        end
    end
endmodule

// File: rtl/irr_router.sv
module irr_router #(
    parameter bit MMODE  = 1'b0,
    parameter int NPAGES = 4,
    parameter int NIDS   = 64,
    parameter int GSEL_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [1:0]                 req_priv,
    input  logic                       req_virt,
    input  logic [GSEL_W-1:0]          req_gsel,
    input  logic [7:0]                 req_sel,
    input  logic                       req_wide,
    input  logic [63:0]                req_wdata,
    input  logic [63:0]                req_wmask,
    input  logic [NPAGES*$clog2(NIDS)-1:0] top_id_i,
    output logic                       rsp_valid,
    output logic                       rsp_err,
    output logic [63:0]                rsp_rdata,
    output logic [NPAGES-1:0]          deliv_o,
    output logic [NPAGES*$clog2(NIDS)-1:0] thresh_o,
    output logic [NPAGES*NIDS-1:0]     pend_o,
    output logic [NPAGES*NIDS-1:0]     en_o
);
    import irr_pkg::*;

    localparam int IDW = $clog2(NIDS);
    localparam int PGW = (NPAGES > 1) ? $clog2(NPAGES) : 1;

    irr_state_e       state_q;
    irr_state_e       state_d;
    irr_op_e          op;
    logic             map_ok;
    logic [PGW-1:0]   page;
    logic [IDW-1:0]   base;
    logic             bad;
    logic             go;
    logic [63:0]      mask_eff;
    logic [IDW-1:0]   tid;
    logic [63:0]      store_rd;
    logic [63:0]      old_val;
    logic [NPAGES-1:0]     deliv_q;
    logic [NPAGES*IDW-1:0] thr_q;
    logic             rsp_err_q;
    logic [63:0]      rsp_rdata_q;

    irr_page_map #(.MMODE(MMODE), .NPAGES(NPAGES), .GSEL_W(GSEL_W), .PGW(PGW)) u_map (
        .priv(req_priv), .virt(req_virt), .gsel(req_gsel), .ok(map_ok), .page(page)
    );

    irr_sel_decode #(.NIDS(NIDS), .IDW(IDW)) u_dec (
        .sel(req_sel), .wide(req_wide), .op(op), .base(base)
    );

    always_comb begin
        bad      = !map_ok || (op == OP_BAD);
        go       = req_valid && !bad;
        mask_eff = req_wide ? req_wmask : {32'b0, req_wmask[31:0]};
        tid      = top_id_i[int'(page) * IDW +: IDW];
    end

    irr_bit_store #(.NPAGES(NPAGES), .NIDS(NIDS), .PGW(PGW), .IDW(IDW)) u_store (
        .clk(clk), .rst_n(rst_n), .page(page), .base(base), .wide(req_wide),
        .use_en(op == OP_ENAB),
        .wr_en(go && ((op == OP_PEND) || (op == OP_ENAB))),
        .wdata(req_wdata), .wmask(mask_eff),
        .clr_en(go && (op == OP_TOP) && (mask_eff != '0) && (tid != '0)),
        .clr_id(tid), .rdata(store_rd), .pend_q(pend_o), .en_q(en_o)
    );

    always_comb begin
        old_val = '0;
        unique case (op)
            OP_DELIV:  old_val[0] = deliv_q[page];
            OP_THRESH: old_val[IDW-1:0] = thr_q[int'(page) * IDW +: IDW];
            OP_TOP: begin
                old_val[IDW-1:0]     = tid;
                old_val[16 +: IDW]   = tid;
            end
            OP_PEND, OP_ENAB: old_val = store_rd;
            default: old_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deliv_q <= '0;
            thr_q   <= '0;
        end else if (go) begin
            if (op == OP_DELIV) begin
                deliv_q[page] <= (deliv_q[page] & ~mask_eff[0]) | (req_wdata[0] & mask_eff[0]);
            end
            if (op == OP_THRESH) begin
                thr_q[int'(page) * IDW +: IDW] <=
                    (thr_q[int'(page) * IDW +: IDW] & ~mask_eff[IDW-1:0]) |
                    (req_wdata[IDW-1:0] & mask_eff[IDW-1:0]);
            end
        end
    end

    always_comb begin
        state_d = req_valid ? ST_RESP : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_err_q   <= req_valid && bad;
            rsp_rdata_q <= go ? old_val : '0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rsp_rdata_q;
    assign deliv_o   = deliv_q;
    assign thresh_o  = thr_q;
endmodule

// File: rtl/irr_router_chk.sv
module irr_router_chk #(
    parameter int NPAGES = 4,
    parameter int NIDS   = 64,
    parameter int IDW    = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic [7:0]              req_sel,
    input logic                    req_wide,
    input logic                    rsp_valid,
    input logic                    rsp_err,
    input logic [63:0]             rsp_rdata,
    input logic [NPAGES-1:0]       deliv_o,
    input logic [NPAGES*IDW-1:0]   thresh_o,
    input logic [NPAGES*NIDS-1:0]  pend_o,
    input logic [NPAGES*NIDS-1:0]  en_o
);
    import irr_pkg::*;

    logic id0_set;
    logic sel_unknown;

    always_comb begin
        id0_set = 1'b0;
        for (int p = 0; p < NPAGES; p++) begin
            id0_set = id0_set | pend_o[p * NIDS] | en_o[p * NIDS];
        end
        sel_unknown = !req_sel[7] && (req_sel != SEL_DELIV) &&
                      (req_sel != SEL_THRESH) && (req_sel != SEL_TOP);
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_RSP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R10
    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($stable(pend_o) && $stable(en_o) &&
                                    $stable(deliv_o) && $stable(thresh_o))); // R10
    AST_ID0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !id0_set); // R7
    AST_WIDE_ODD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wide && req_sel[7] && req_sel[0]) |=> rsp_err); // R4
    AST_UNKNOWN_SEL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel_unknown) |=> rsp_err); // R3
endmodule

bind irr_router irr_router_chk #(.NPAGES(NPAGES), .NIDS(NIDS), .IDW(IDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_wide(req_wide), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .deliv_o(deliv_o), .thresh_o(thresh_o),
    .pend_o(pend_o), .en_o(en_o)
);

// File: tb/sim_irr_router.sv
`timescale 1ns/1ps
module sim_irr_router;
    localparam int NP  = 4;
    localparam int NI  = 64;
    localparam int IDW = 6;
    localparam int GW  = 6;

    typedef struct {
        string       tag;
        logic        err;
        logic [63:0] data;
        logic        err1;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_priv = '0;
    logic req_virt = 1'b0;
    logic [GW-1:0] req_gsel = '0;
    logic [7:0] req_sel = '0;
    logic req_wide = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_wmask = '0;
    logic [NP*IDW-1:0] top_vec = '0;

    logic rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [NP-1:0] deliv_o;
    logic [NP*IDW-1:0] thresh_o;
    logic [NP*NI-1:0] pend_o, en_o;

    logic rsp_valid1, rsp_err1;
    logic [63:0] rsp_rdata1;
    logic [0:0] deliv1;
    logic [IDW-1:0] thresh1;
    logic [NI-1:0] pend1, en1;

    logic [NP*NI-1:0] pm = '0;
    logic [NP*NI-1:0] em = '0;
    logic [NP-1:0] dm = '0;
    logic [NP*IDW-1:0] tm = '0;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irr_router #(.MMODE(1'b0), .NPAGES(NP), .NIDS(NI), .GSEL_W(GW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
        .req_virt(req_virt), .req_gsel(req_gsel), .req_sel(req_sel),
        .req_wide(req_wide), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .top_id_i(top_vec), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .deliv_o(deliv_o), .thresh_o(thresh_o),
        .pend_o(pend_o), .en_o(en_o)
    );

    irr_router #(.MMODE(1'b1), .NPAGES(1), .NIDS(NI), .GSEL_W(GW)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
        .req_virt(req_virt), .req_gsel(req_gsel), .req_sel(req_sel),
        .req_wide(req_wide), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .top_id_i(top_vec[IDW-1:0]), .rsp_valid(rsp_valid1), .rsp_err(rsp_err1),
        .rsp_rdata(rsp_rdata1), .deliv_o(deliv1), .thresh_o(thresh1),
        .pend_o(pend1), .en_o(en1)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic chk_state(input string rq);
        check(pend_o === pm, rq, "pending state", pend_o, pm);
        check(en_o === em, rq, "enable state", en_o, em);
        check(deliv_o === dm, rq, "delivery state", 256'(deliv_o), 256'(dm));
        check(thresh_o === tm, rq, "threshold state", 256'(thresh_o), 256'(tm));
    endtask

    // Driver: computes the expected response from the requirements and queues it
    task automatic req(input logic [1:0] pv, input bit vt, input logic [GW-1:0] gs,
                       input logic [7:0] sel, input bit wd, input logic [63:0] dat,
                       input logic [63:0] msk, input string tag);
        exp_t e;
        bit map_ok, dec_ok;
        int pg, kind, base, w, n, tid;
        logic [63:0] rd, m;
        map_ok = 1'b0; pg = 0;
        if (pv == 2'b01 && !vt) map_ok = 1'b1;
        else if (pv == 2'b01 && vt && gs != 0 && int'(gs) < NP) begin
            map_ok = 1'b1; pg = int'(gs);
        end
        dec_ok = 1'b1; kind = 0; base = 0; n = int'(sel[5:0]);
        w = wd ? 64 : 32;
        if (sel == 8'h70) kind = 0;
        else if (sel == 8'h72) kind = 1;
        else if (sel == 8'h74) kind = 2;
        else if (sel[7]) begin
            kind = sel[6] ? 4 : 3;
            if (wd) begin
                dec_ok = (n % 2 == 0) && (n / 2 < NI / 64); base = (n / 2) * 64;
            end else begin
                dec_ok = n < NI / 32; base = n * 32;
            end
        end else dec_ok = 1'b0;
        m = wd ? msk : {32'b0, msk[31:0]};
        e.tag = tag;
        e.err = !(map_ok && dec_ok);
        e.err1 = !((pv == 2'b11) && !vt && dec_ok);
        rd = '0;
        if (!e.err) begin
            case (kind)
                0: begin
                    rd[0] = dm[pg];
                    if (m[0]) dm[pg] = dat[0];
                end
                1: begin
                    rd[IDW-1:0] = tm[pg*IDW +: IDW];
                    tm[pg*IDW +: IDW] = (tm[pg*IDW +: IDW] & ~m[IDW-1:0]) | (dat[IDW-1:0] & m[IDW-1:0]);
                end
                2: begin
                    tid = int'(top_vec[pg*IDW +: IDW]);
                    rd[IDW-1:0] = IDW'(tid);
                    rd[16 +: IDW] = IDW'(tid);
                    if (m != 0 && tid != 0) pm[pg*NI + tid] = 1'b0;
                end
                default: begin
                    for (int i = 0; i < w; i++) begin
                        rd[i] = (kind == 4) ? em[pg*NI + base + i] : pm[pg*NI + base + i];
                        if (m[i] && (base + i != 0)) begin
                            if (kind == 4) em[pg*NI + base + i] = dat[i];
                            else pm[pg*NI + base + i] = dat[i];
                        end
                    end
                end
            endcase
        end
        e.data = rd;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_priv = pv; req_virt = vt; req_gsel = gs;
        req_sel = sel; req_wide = wd; req_wdata = dat; req_wmask = msk;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R10", "unexpected response", 256'(1), 256'(0));
            end else begin
                exp_t e;
                e = q.pop_front();
                check({rsp_err, rsp_rdata} === {e.err, e.data}, e.tag, "err,rdata",
                      256'({rsp_err, rsp_rdata}), 256'({e.err, e.data}));
                check(rsp_valid1 && (rsp_err1 === e.err1), "R1", {e.tag, " mmode err"},
                      256'(rsp_err1), 256'(e.err1));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R10", "rsp_valid in reset", 256'(rsp_valid), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R7");
        // R8 delivery
        req(2'b01, 0, 0, 8'h70, 0, 64'h1, 64'h1, "R8");
        req(2'b01, 0, 0, 8'h70, 0, 64'h0, 64'h0, "R8");
        // R8 threshold on guest page 2
        req(2'b01, 1, 2, 8'h72, 0, 64'h2A, 64'h3F, "R8");
        req(2'b01, 1, 2, 8'h72, 0, 64'h3F, 64'h0F, "R8");
        req(2'b01, 1, 2, 8'h72, 0, 64'h0, 64'h0, "R8");
        // R5 R6 R7 pending words
        req(2'b01, 0, 0, 8'h80, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        req(2'b01, 0, 0, 8'h80, 0, 64'h0, 64'h0, "R7");
        req(2'b01, 0, 0, 8'h81, 0, 64'h0000_AA00, 64'h0000_FF00, "R6");
        req(2'b01, 0, 0, 8'h80, 1, 64'h0, 64'h0, "R5");
        // R4 index checks
        req(2'b01, 0, 0, 8'h81, 1, 64'hFF, 64'hFF, "R4");
        req(2'b01, 0, 0, 8'h82, 1, 64'hFF, 64'hFF, "R4");
        req(2'b01, 0, 0, 8'h82, 0, 64'hFF, 64'hFF, "R4");
        // enable words on page 3
        req(2'b01, 1, 3, 8'hC0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_00F1, "R7");
        req(2'b01, 1, 3, 8'hC0, 1, 64'h0, 64'h30, "R6");
        req(2'b01, 1, 3, 8'hC0, 1, 64'h0, 64'h0, "R5");
        req(2'b01, 1, 3, 8'hC1, 0, 64'hFFFF_FFFF_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        req(2'b01, 1, 3, 8'hC0, 1, 64'h0, 64'h0, "R5");
        @(negedge clk); @(negedge clk);
        chk_state("R6");
        // R2 mapping errors, with a write that must be ignored
        req(2'b01, 1, 0, 8'h80, 0, 64'h0, 64'hFFFF_FFFF, "R2");
        req(2'b01, 1, 4, 8'h80, 0, 64'h0, 64'hFFFF_FFFF, "R2");
        req(2'b01, 1, 5, 8'h70, 0, 64'h1, 64'h1, "R2");
        req(2'b00, 0, 0, 8'h80, 0, 64'h0, 64'hFFFF_FFFF, "R2");
        req(2'b11, 0, 0, 8'h80, 0, 64'h0, 64'hFFFF_FFFF, "R1");
        req(2'b11, 1, 0, 8'h70, 0, 64'h1, 64'h1, "R1");
        req(2'b01, 1, 1, 8'hC0, 0, 64'h0, 64'h0, "R2");
        // R3 unknown codes
        req(2'b01, 0, 0, 8'h71, 0, 64'h1, 64'h1, "R3");
        req(2'b01, 0, 0, 8'h00, 0, 64'h1, 64'h1, "R3");
        req(2'b01, 0, 0, 8'h7F, 0, 64'h1, 64'h1, "R3");
        @(negedge clk); @(negedge clk);
        chk_state("R10");
        // R9 top-interrupt
        top_vec[0 +: IDW] = 6'd5;
        top_vec[2*IDW +: IDW] = 6'd0;
        req(2'b01, 0, 0, 8'h74, 0, 64'h0, 64'h0, "R9");
        req(2'b01, 0, 0, 8'h74, 0, 64'h0, 64'h1, "R9");
        req(2'b01, 0, 0, 8'h80, 0, 64'h0, 64'h0, "R9");
        req(2'b01, 0, 0, 8'h74, 1, 64'h0, 64'hFFFF_FFFF_0000_0000, "R9");
        req(2'b01, 1, 2, 8'h74, 0, 64'h0, 64'hFF, "R9");
        top_vec[0 +: IDW] = 6'd40;
        req(2'b01, 0, 0, 8'h74, 0, 64'h0, 64'hFFFF_FFFF_0000_0000, "R9");
        req(2'b01, 0, 0, 8'h74, 1, 64'h0, 64'h1_0000_0000, "R9");
        @(negedge clk); @(negedge clk);
        chk_state("R9");
        check(q.size() == 0, "R10", "responses outstanding", 256'(q.size()), 256'(0));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule